// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Register Bank

This block generates up to four independent pulse-width modulated outputs from one clock. Each channel has its own power-of-two clock divider, a 16-bit counter, and a compare against a duty value. The counter runs in one of two shapes. In edge mode it ramps up and wraps. In symmetric mode it ramps up to the period and back down. The channel output is at its active level while the counter is below the duty value, and a bit in the channel setup chooses whether that active level is high or low.

Software reaches the block through a simple word-addressed read/write bus that completes in one cycle, with read data valid in the same cycle as the access. Channels are started and stopped through write-one set and clear registers. Once a channel runs, its duty and period can only be changed through a staging register. The staged value is applied at the next period boundary, so no pulse is ever cut short. Every channel flags the end of each period in a sticky status register. A read of that register clears it. A mask register selects which status bits drive the single interrupt line.

Top module: `pwm_bank`

## Requirements
- R1: After reset the run status (0x0C), interrupt mask (0x18) and interrupt status (0x1C) read zero, the global setup word at 0x00 reads zero, and every output pin sits at its inactive level, which is high because polarity resets to 0.
- R2: A write to 0x04 starts channel n for each 1 in bit n, and a write to 0x08 stops channel n for each 1 in bit n. Zero bits change nothing. Bit n of 0x0C reads 1 while channel n runs, and an all-ones write to 0x08 stops every channel.
- R3: Channel n's window starts at byte address 0x200 + n*0x20, holding setup (+0x00), duty (+0x04), period (+0x08), counter (+0x0C) and staging (+0x10). In the setup word, bits 3:0 are the divider exponent, bit 8 selects symmetric counting, bit 9 is polarity (1 = active high) and bit 10 is the staging target. Every other setup bit reads zero, so an all-ones write reads back 0x70F.
- R4: Duty, period and staging keep only the low 16 bits of a write.
- R5: The counter advances once every 2^e clocks, where e is the divider exponent. Exponents above 10 behave as 10.
- R6: In edge mode the counter runs 0..period-1 and wraps. The period end coincides with the wrap, and the output is active for duty clocks out of every period.
- R7: In symmetric mode the counter climbs from 0 to the period and falls back to 0. The period end is at the return to 0, which makes a period 2*period counts long.
- R8: A stopped channel holds its pin at the inactive level and its counter at 0, and writes to its duty or period take effect at once. A staging write to a stopped channel goes straight to its target.
- R9: While a channel runs, direct writes to duty and period are ignored. A staging write is held and applied at the next period end, to duty when setup bit 10 is 0 and to period when it is 1.
- R10: Bit n of 0x1C sets at every period end of channel n and stays set until a read of 0x1C clears the register. A period end in the same cycle as that read leaves the bit set.
- R11: A write of ones to 0x10 sets mask bits and a write of ones to 0x14 clears them; mask bits read at 0x18. The interrupt output is high whenever some status bit and its mask bit are both set, and an all-ones write to 0x14 masks everything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus, dividers and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| pwm_o | output | 4 | One modulated output per channel |
| irq_o | output | 1 | Unmasked period-end interrupt |

## Verification
The assertions assume that the bus carries one access per strobe and that a channel's counter only meets a new period at a period end or while the channel is stopped. For that reason the range check on the counter holds only if period changes reach a running channel through the staging register. The stimulus keeps to this. It writes duty and period directly only to stopped channels, changes a running channel only through staging, and when it writes duty or period directly to a running channel, it is to show that the write is ignored. Pin checks count active samples over whole periods, so they do not depend on the phase of the counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // global register word slots (byte offset / 4)
   localparam int unsigned G_SETUP  = 0;
   localparam int unsigned G_START  = 1;
   localparam int unsigned G_STOP   = 2;
   localparam int unsigned G_RUN    = 3;
   localparam int unsigned G_IMSET  = 4;
   localparam int unsigned G_IMCLR  = 5;
   localparam int unsigned G_IMASK  = 6;
   localparam int unsigned G_ISTAT  = 7;

   // channel window word slots
   localparam int unsigned C_SETUP  = 0;
   localparam int unsigned C_DUTY   = 1;
   localparam int unsigned C_PERIOD = 2;
   localparam int unsigned C_COUNT  = 3;
   localparam int unsigned C_STAGE  = 4;

   // channel setup bit positions
   localparam int unsigned B_SYMM   = 8;
   localparam int unsigned B_POL    = 9;
   localparam int unsigned B_TGT    = 10;

   // channel window size in bytes (5 address bits)
   localparam int unsigned WIN_BYTES = 32;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int EXP_W   = 4,
   parameter int EXP_MAX = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);
   localparam int PW = EXP_MAX;

   logic [PW-1:0]    pcnt_q;
   logic [EXP_W-1:0] exp_eff;
   logic [PW-1:0]    lim;

   assign exp_eff = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
   assign lim     = ({{(PW-1){1'b0}}, 1'b1} << exp_eff) - 1'b1;
   assign tick_o  = en && ((pcnt_q & lim) == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pcnt_q <= '0;
      else if (!en) pcnt_q <= '0;
      else         pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          symm,
   input  logic [CW-1:0] per,
   output logic [CW-1:0] cnt_o,
   output logic          end_o
);
   logic [CW-1:0] cnt_q;
   logic          dn_q;
   logic          wrap_edge;
   logic          top_hit;
   logic          end_symm;

   assign wrap_edge = (per == '0) || (cnt_q >= per - 1'b1);
   assign top_hit   = (cnt_q >= per);
   assign end_symm  = dn_q ? (cnt_q <= CW'(1)) : (top_hit && per <= CW'(1));
   assign end_o     = en && tick && (symm ? end_symm : wrap_edge);
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dn_q  <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         dn_q  <= 1'b0;
      end else if (tick) begin
         if (symm) begin
            if (!dn_q) begin
               if (top_hit) begin
                  if (per <= CW'(1)) cnt_q <= '0;
                  else begin
                     cnt_q <= cnt_q - 1'b1;
                     dn_q  <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else if (cnt_q <= CW'(1)) begin
               cnt_q <= '0;
               dn_q  <= 1'b0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else begin
            dn_q  <= 1'b0;
            cnt_q <= wrap_edge ? '0 : cnt_q + 1'b1;
         end
      end
   end

   // R8
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_o == '0));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= per);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_pkg::*;
#(
   parameter int CW       = 16,
   parameter int EXP_W    = 4,
   parameter int EXP_MAX  = 10,
   parameter bit SYMM_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             setup_we,
   input  logic             duty_we,
   input  logic             per_we,
   input  logic             stage_we,
   input  logic [EXP_W-1:0] exp_wd,
   input  logic             symm_wd,
   input  logic             pol_wd,
   input  logic             tgt_wd,
   input  logic [CW-1:0]    val_wd,
   output logic [31:0]      setup_rd,
   output logic [CW-1:0]    duty_rd,
   output logic [CW-1:0]    per_rd,
   output logic [CW-1:0]    cnt_rd,
   output logic [CW-1:0]    stage_rd,
   output logic             pwm_o,
   output logic             end_o
);
   logic [EXP_W-1:0] exp_q;
   logic             pol_q;
   logic             tgt_q;
   logic             symm_q;
   logic [CW-1:0]    duty_q;
   logic [CW-1:0]    per_q;
   logic [CW-1:0]    stage_q;
   logic             pend_q;
   logic             tick;
   logic [CW-1:0]    cnt;
   logic             per_end;

   generate
      if (SYMM_EN) begin : g_symm
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        symm_q <= 1'b0;
            else if (setup_we) symm_q <= symm_wd;
         end
      end else begin : g_edge_only
         logic unused_symm;
         assign unused_symm = symm_wd;
         assign symm_q      = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= '0;
         pol_q <= 1'b0;
         tgt_q <= 1'b0;
      end else if (setup_we) begin
         exp_q <= exp_wd;
         pol_q <= pol_wd;
         tgt_q <= tgt_wd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q  <= '0;
         per_q   <= '0;
         stage_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (!en) begin
            pend_q <= 1'b0;
            if (duty_we) duty_q <= val_wd;
            if (per_we)  per_q  <= val_wd;
            if (stage_we) begin
               stage_q <= val_wd;
               if (tgt_q) per_q  <= val_wd;
               else       duty_q <= val_wd;
            end
         end else begin
            if (per_end && pend_q) begin
               pend_q <= 1'b0;
               if (tgt_q) per_q  <= stage_q;
               else       duty_q <= stage_q;
            end
            if (stage_we) begin
               stage_q <= val_wd;
               pend_q  <= 1'b1;
            end
         end
      end
   end

   pwm_prescale #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .exp_i  (exp_q),
      .tick_o (tick)
   );

   pwm_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .tick  (tick),
      .symm  (symm_q),
      .per   (per_q),
      .cnt_o (cnt),
      .end_o (per_end)
   );

   always_comb begin
      setup_rd               = '0;
      setup_rd[EXP_W-1:0]    = exp_q;
      setup_rd[B_SYMM]       = symm_q;
      setup_rd[B_POL]        = pol_q;
      setup_rd[B_TGT]        = tgt_q;
   end

   assign duty_rd  = duty_q;
   assign per_rd   = per_q;
   assign cnt_rd   = cnt;
   assign stage_rd = stage_q;
   assign end_o    = per_end;
   assign pwm_o    = (en && (cnt < duty_q)) ? pol_q : ~pol_q;

   // R8
   idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en) && $stable(pol_q)) |-> $stable(pwm_o));
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_i,
   input  logic           mset_we,
   input  logic           mclr_we,
   input  logic [NCH-1:0] wd,
   input  logic           rd_clr,
   output logic [NCH-1:0] stat_o,
   output logic [NCH-1:0] mask_o,
   output logic           irq_o
);
   logic [NCH-1:0] stat_q;
   logic [NCH-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (rd_clr ? '0 : stat_q) | set_i;
         if (mset_we)      mask_q <= mask_q | wd;
         else if (mclr_we) mask_q <= mask_q & ~wd;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;
   assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int CW       = 16,
   parameter int AW       = 12,
   parameter int EXP_W    = 4,
   parameter int EXP_MAX  = 10,
   parameter int CH_BASE  = 'h200,
   parameter bit SYMM_EN  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_sel,
   input  logic           bus_wr,
   input  logic [AW-1:0]  bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic [NCH-1:0] pwm_o,
   output logic           irq_o
);
   localparam int SLOT_W    = AW - 5;
   localparam int BASE_SLOT = CH_BASE / WIN_BYTES;

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("pwm_bank: NCH must lie in 1..32");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("pwm_bank: CW must lie in 2..32");
      end
      if (EXP_MAX < 1 || EXP_MAX >= (1 << EXP_W)) begin : g_bad_exp
         $error("pwm_bank: EXP_MAX must be encodable in EXP_W bits");
      end
      if (EXP_W > 8) begin : g_bad_expw
         $error("pwm_bank: EXP_W must not reach the symmetric-mode bit");
      end
      if ((CH_BASE % WIN_BYTES) != 0 || CH_BASE < WIN_BYTES ||
          CH_BASE + NCH * WIN_BYTES > (1 << AW)) begin : g_bad_map
         $error("pwm_bank: channel windows must be aligned and fit the address space");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_raw;
   logic [SLOT_W-1:0] slot;
   logic              g_hit;
   logic              ch_hit;
   logic [2:0]        widx;
   logic              wr_g;
   logic              rd_g;
   logic [NCH-1:0]    run_q;
   logic [NCH-1:0]    ends;
   logic [NCH-1:0]    stat;
   logic [NCH-1:0]    mask;
   logic [31:0]       g_rd;
   logic [31:0]       ch_rd;
   logic [31:0]       ch_rdv [NCH];
   logic              unused_bits;

   assign slot_raw = bus_addr[AW-1:5];
   assign slot     = slot_raw - SLOT_W'(BASE_SLOT);
   assign g_hit    = (slot_raw == '0);
   assign ch_hit   = (slot_raw >= SLOT_W'(BASE_SLOT)) && (slot < SLOT_W'(NCH));
   assign widx     = bus_addr[4:2];
   assign wr_g     = bus_sel && bus_wr && g_hit;
   assign rd_g     = bus_sel && !bus_wr && g_hit;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (wr_g && widx == 3'(G_START)) run_q <= run_q | bus_wdata[NCH-1:0];
      else if (wr_g && widx == 3'(G_STOP))  run_q <= run_q & ~bus_wdata[NCH-1:0];
   end

   pwm_irq #(.NCH(NCH)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ends),
      .mset_we (wr_g && widx == 3'(G_IMSET)),
      .mclr_we (wr_g && widx == 3'(G_IMCLR)),
      .wd      (bus_wdata[NCH-1:0]),
      .rd_clr  (rd_g && widx == 3'(G_ISTAT)),
      .stat_o  (stat),
      .mask_o  (mask),
      .irq_o   (irq_o)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         logic          cw;
         logic [31:0]   setup_rd;
         logic [CW-1:0] duty_rd, per_rd, cnt_rd, stage_rd;

         assign cw = bus_sel && bus_wr && ch_hit && (slot == SLOT_W'(gi));

         pwm_chan #(
            .CW(CW), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .SYMM_EN(SYMM_EN)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (run_q[gi]),
            .setup_we (cw && widx == 3'(C_SETUP)),
            .duty_we  (cw && widx == 3'(C_DUTY)),
            .per_we   (cw && widx == 3'(C_PERIOD)),
            .stage_we (cw && widx == 3'(C_STAGE)),
            .exp_wd   (bus_wdata[EXP_W-1:0]),
            .symm_wd  (bus_wdata[B_SYMM]),
            .pol_wd   (bus_wdata[B_POL]),
            .tgt_wd   (bus_wdata[B_TGT]),
            .val_wd   (bus_wdata[CW-1:0]),
            .setup_rd (setup_rd),
            .duty_rd  (duty_rd),
            .per_rd   (per_rd),
            .cnt_rd   (cnt_rd),
            .stage_rd (stage_rd),
            .pwm_o    (pwm_o[gi]),
            .end_o    (ends[gi])
         );

         always_comb begin
            case (widx)
               3'(C_SETUP):  ch_rdv[gi] = setup_rd;
               3'(C_DUTY):   ch_rdv[gi] = 32'(duty_rd);
               3'(C_PERIOD): ch_rdv[gi] = 32'(per_rd);
               3'(C_COUNT):  ch_rdv[gi] = 32'(cnt_rd);
               3'(C_STAGE):  ch_rdv[gi] = 32'(stage_rd);
               default:      ch_rdv[gi] = '0;
            endcase
         end

         // R2
         start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_g && widx == 3'(G_START) && bus_wdata[gi]) |=> run_q[gi]);

         // R10
         stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[gi]) |-> $past(run_q[gi]));
      end
   endgenerate

   always_comb begin
      ch_rd = '0;
      for (int i = 0; i < NCH; i++)
         if (ch_hit && slot == SLOT_W'(i)) ch_rd = ch_rdv[i];
   end

   always_comb begin
      case (widx)
         3'(G_RUN):   g_rd = 32'(run_q);
         3'(G_IMASK): g_rd = 32'(mask);
         3'(G_ISTAT): g_rd = 32'(stat);
         default:     g_rd = '0;
      endcase
   end

   assign bus_rdata = g_hit ? g_rd : ch_rd;
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] expv;
      logic [31:0] msk;
      string       tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   pwm_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_o(pwm_o), .irq_o(irq_o)
   );

   // monitor: compares each read against the queued expectation
   always @(negedge clk) begin
      if (rst_n && bus_sel && !bus_wr) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL read with empty scoreboard actual=%h expected=none", bus_rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            if ((bus_rdata & it.msk) !== (it.expv & it.msk)) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.tag,
                        bus_rdata & it.msk, it.expv & it.msk);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e,
                     input logic [31:0] m, input string tag);
      item_t it;
      it.expv = e; it.msk = m; it.tag = tag;
      @(posedge clk); #1;
      sb.push_back(it);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, e);
      end
   endtask

   task automatic count_hi(input int ch, input int n, input int e, input string tag);
      int hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_o[ch]) hi++;
      end
      chk(32'(hi), 32'(e), tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(32'(pwm_o), 32'hF, "R1 pins idle high");
      chk(32'(irq_o), 0, "R1 irq low");
      rd(12'h00C, 0, '1, "R1 run status");
      rd(12'h018, 0, '1, "R1 mask");
      rd(12'h01C, 0, '1, "R1 int status");
      rd(12'h000, 0, '1, "R1 global setup");
      rd(12'h200, 0, '1, "R1 ch0 setup");

      wr(12'h220, 32'hFFFF_FFFF);
      rd(12'h220, 32'h70F, '1, "R3 setup field mask");
      wr(12'h220, 0);

      wr(12'h204, 32'h0001_2345);
      rd(12'h204, 32'h2345, '1, "R4 duty width");
      wr(12'h208, 32'h000A_BCDE);
      rd(12'h208, 32'hBCDE, '1, "R4 period width");
      wr(12'h210, 32'h000F_0001);
      rd(12'h210, 32'h0001, '1, "R4 staging width");
      rd(12'h204, 32'h0001, '1, "R8 stopped staging to duty");

      wr(12'h004, 5);
      rd(12'h00C, 5, '1, "R2 start 0101");
      wr(12'h004, 2);
      rd(12'h00C, 7, '1, "R2 start adds bit1");
      wr(12'h008, 4);
      rd(12'h00C, 3, '1, "R2 stop bit2");
      wr(12'h008, 0);
      rd(12'h00C, 3, '1, "R2 zero stop no effect");
      wr(12'h008, 32'hFFFF_FFFF);
      rd(12'h00C, 0, '1, "R2 stop all");
      rd(12'h01C, 0, 0, "R10 clear");
      rd(12'h01C, 0, '1, "R10 read clears");

      // ch0: edge mode, active high, period 5, duty 2
      wr(12'h200, 32'h200);
      wr(12'h204, 2);
      wr(12'h208, 5);
      @(negedge clk);
      chk(32'(pwm_o[0]), 0, "R8 stopped pin inactive low");
      rd(12'h20C, 0, '1, "R8 stopped counter zero");
      wr(12'h004, 1);
      repeat (3) @(posedge clk);
      rd(12'h01C, 0, 1, "R10 before first period end");
      rd(12'h01C, 1, 1, "R10 at first period end");
      count_hi(0, 20, 8, "R6 duty 2 of 5");
      wr(12'h204, 4);
      rd(12'h204, 2, '1, "R9 direct duty ignored");
      count_hi(0, 20, 8, "R9 waveform unchanged");
      wr(12'h210, 3);
      repeat (8) @(posedge clk);
      rd(12'h204, 3, '1, "R9 staged duty applied");
      count_hi(0, 20, 12, "R6 duty 3 of 5");
      wr(12'h200, 32'h600);
      wr(12'h210, 10);
      repeat (12) @(posedge clk);
      rd(12'h208, 10, '1, "R9 staged period applied");
      count_hi(0, 20, 6, "R6 duty 3 of 10");

      // ch1: divider exponent 4, period 10
      wr(12'h220, 32'h004);
      wr(12'h224, 1);
      wr(12'h228, 10);
      wr(12'h004, 2);
      repeat (40) @(posedge clk);
      rd(12'h22C, 2, '1, "R5 counter steps per 16 clocks");
      wr(12'h230, 7);
      rd(12'h224, 1, '1, "R9 staged duty held until period end");
      repeat (130) @(posedge clk);
      rd(12'h224, 7, '1, "R9 staged duty after period end");

      // ch3: exponent 15 behaves as 10
      wr(12'h260, 32'h00F);
      wr(12'h268, 100);
      wr(12'h004, 8);
      repeat (1030) @(posedge clk);
      rd(12'h26C, 1, '1, "R5 exponent clamp");

      // ch2: symmetric, active high, period 4, duty 2
      wr(12'h240, 32'h300);
      wr(12'h244, 2);
      wr(12'h248, 4);
      wr(12'h004, 4);
      repeat (6) @(posedge clk);
      rd(12'h01C, 0, 4, "R7 no end before bottom");
      rd(12'h01C, 4, 4, "R7 end at bottom");
      count_hi(2, 16, 6, "R7 symmetric duty");

      wr(12'h010, 4);
      rd(12'h018, 4, '1, "R11 mask set");
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(32'(irq_o), 1, "R11 irq raised");
      wr(12'h014, 32'hFFFF_FFFF);
      rd(12'h018, 0, '1, "R11 mask all cleared");
      @(negedge clk);
      chk(32'(irq_o), 0, "R11 irq masked");

      wr(12'h008, 32'hFFFF_FFFF);
      @(negedge clk);
      chk(32'(pwm_o), 32'hA, "R8 stopped pins at inactive level");
      rd(12'h00C, 0, '1, "R2 all stopped");
      rd(12'h20C, 0, '1, "R8 counter cleared on stop");
      rd(12'h01C, 0, 0, "R10 clear");
      rd(12'h01C, 0, '1, "R10 stays clear when stopped");

      repeat (2) @(posedge clk);
      chk(32'(sb.size()), 0, "scoreboard drained");
      done = 1'b1;
   end

   initial begin
      int n = 0;
      while (!done && n < 20000) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule